// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Overflow-Corrected Signed Compare

This block is a combinational integer ALU assembled from a row of identical single-bit slices plus one distinct slice for the top bit. Every slice forms AND, OR and a full-adder sum from its operand bits. Either operand bit can be inverted inside the slice. A single carry-in at bit 0 turns the ripple adder into a subtractor.

The top slice also produces the signed overflow flag and a "set" bit. The set bit is the top sum bit XORed with overflow, so it gives the true sign of a − b even when the subtraction wraps. It is routed back into the "less" input of bit 0 to form the signed set-on-less-than result.

A 4-bit operation code selects the function. The width is a parameter. Result, zero flag and overflow flag are all combinational and settle in the same cycle as the operands.

Top module: `bitslice_alu`

## Requirements
- R1: Code 4'b0000 (AND) drives result_o = a_i & b_i.
- R2: Code 4'b0001 (OR) drives result_o = a_i | b_i.
- R3: Code 4'b0010 (add) drives result_o = (a_i + b_i) mod 2^WIDTH. overflow_o is 1 exactly when both operands have the same sign bit and the sign bit of the sum differs from it.
- R4: Code 4'b0110 (subtract) drives result_o = (a_i − b_i) mod 2^WIDTH. overflow_o is 1 exactly when the operand sign bits differ and the sign bit of the difference differs from the sign bit of a_i.
- R5: Code 4'b0111 (signed less-than) sets result_o[0] to 1 exactly when a_i < b_i as two's-complement values, and holds result_o[WIDTH-1:1] at zero. This holds also when a_i − b_i overflows, for example most-negative < 1 and most-positive versus −1.
- R6: Code bit 3 inverts a_i in every slice and code bit 2 inverts b_i in every slice. Bit 2 also feeds the carry into bit 0. Code 4'b1100 therefore yields ~(a_i | b_i).
- R7: zero_o is 1 exactly when every bit of result_o is 0.
- R8: The block holds no state. All outputs follow the inputs within the same cycle, and no clock edge is needed.
- R9: The WIDTH parameter sets the slice count. At WIDTH = 4, less-than is correct for all 256 operand pairs; in particular −7 (4'b1001) < 6 (4'b0110) gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_code_i | input | 4 | {invert a, negate b, select[1:0]}; select 00 AND, 01 OR, 10 sum, 11 less |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |
| overflow_o | output | 1 | Signed overflow of the adder |

## Verification
Every result of this block is due zero cycles after its stimulus, because the slices and the top-bit set path are pure combinational logic. The bench drives operands and the operation code on a falling clock edge. It samples result, zero and overflow a quarter period later, before any rising edge, so no check can depend on a register. Random operands are skewed toward the most-negative, most-positive, −1, 0 and 1 values, which is where the raw sign bit and the corrected set bit disagree. A second 4-bit instance is swept exhaustively for the compare and subtract overflow.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

  typedef struct packed {
    logic a_inv;
    logic b_neg;
    sel_e sel;
  } ctrl_t;

  localparam logic [3:0] CODE_AND = 4'b0000;
  localparam logic [3:0] CODE_OR  = 4'b0001;
  localparam logic [3:0] CODE_ADD = 4'b0010;
  localparam logic [3:0] CODE_SUB = 4'b0110;
  localparam logic [3:0] CODE_SLT = 4'b0111;
  localparam logic [3:0] CODE_NOR = 4'b1100;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] op_code_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o.a_inv = op_code_i[3];
    ctrl_o.b_neg = op_code_i[2];
    ctrl_o.sel   = sel_e'(op_code_i[1:0]);
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic a_inv_i,
  input  logic b_inv_i,
  input  logic carry_i,
  input  logic less_i,
  input  sel_e sel_i,
  output logic res_o,
  output logic carry_o
);

  logic a_s, b_s, p, sum;

  assign a_s     = a_i ^ a_inv_i;
  assign b_s     = b_i ^ b_inv_i;
  assign p       = a_s ^ b_s;
  assign sum     = p ^ carry_i;
  assign carry_o = (a_s & b_s) | (carry_i & p);

  always_comb begin
    unique case (sel_i)
      SEL_AND: res_o = a_s & b_s;
      SEL_OR:  res_o = a_s | b_s;
      SEL_SUM: res_o = sum;
      default: res_o = less_i;
    endcase
  end

endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
  import alu_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic a_inv_i,
  input  logic b_inv_i,
  input  logic carry_i,
  input  logic less_i,
  input  sel_e sel_i,
  output logic res_o,
  output logic set_o,
  output logic ovf_o
);

  logic a_s, b_s, p, sum, carry_out;

  assign a_s       = a_i ^ a_inv_i;
  assign b_s       = b_i ^ b_inv_i;
  assign p         = a_s ^ b_s;
  assign sum       = p ^ carry_i;
  assign carry_out = (a_s & b_s) | (carry_i & p);

  // signed overflow: carry into top bit differs from carry out
  assign ovf_o = carry_i ^ carry_out;
  // true sign of the difference, corrected for wrap
  assign set_o = sum ^ ovf_o;

  always_comb begin
    unique case (sel_i)
      SEL_AND: res_o = a_s & b_s;
      SEL_OR:  res_o = a_s | b_s;
      SEL_SUM: res_o = sum;
      default: res_o = less_i;
    endcase
  end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_code_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o
);

  localparam int MSB = WIDTH - 1;

  ctrl_t ctrl;
  logic  set;

  alu_ctrl u_ctrl (
    .op_code_i (op_code_i),
    .ctrl_o    (ctrl)
  );

  for (genvar i = 0; i < MSB; i++) begin : g_slice
    logic c_in;
    logic c_out;
    logic less;

    if (i == 0) begin : g_first
      assign c_in = ctrl.b_neg;
      assign less = set;
    end else begin : g_rest
      assign c_in = g_slice[i-1].c_out;
      assign less = 1'b0;
    end

    alu_slice u_slice (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .a_inv_i (ctrl.a_inv),
      .b_inv_i (ctrl.b_neg),
      .carry_i (c_in),
      .less_i  (less),
      .sel_i   (ctrl.sel),
      .res_o   (result_o[i]),
      .carry_o (c_out)
    );
  end

  alu_msb_slice u_msb (
    .a_i     (a_i[MSB]),
    .b_i     (b_i[MSB]),
    .a_inv_i (ctrl.a_inv),
    .b_inv_i (ctrl.b_neg),
    .carry_i (g_slice[MSB-1].c_out),
    .less_i  (1'b0),
    .sel_i   (ctrl.sel),
    .res_o   (result_o[MSB]),
    .set_o   (set),
    .ovf_o   (overflow_o)
  );

  assign zero_o = ~|result_o;

endmodule

// File: rtl/alu_check.sv
module alu_check
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       op_code_i,
  input logic [WIDTH-1:0] result_o,
  input logic             overflow_o
);

  logic [WIDTH-1:0] sum_ref, dif_ref, lt_ref;
  logic             add_ovf_ref;

  always_comb begin
    sum_ref     = a_i + b_i;
    dif_ref     = a_i - b_i;
    lt_ref      = '0;
    lt_ref[0]   = $signed(a_i) < $signed(b_i);
    add_ovf_ref = (a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_ref[WIDTH-1] != a_i[WIDTH-1]);
  end

  always_comb begin
    if (op_code_i == CODE_AND) begin
      assert_and_R1: assert (result_o == (a_i & b_i)) else $error("R1 and mismatch");
    end
    if (op_code_i == CODE_OR) begin
      assert_or_R2: assert (result_o == (a_i | b_i)) else $error("R2 or mismatch");
    end
    if (op_code_i == CODE_ADD) begin
      assert_sum_R3: assert (result_o == sum_ref) else $error("R3 sum mismatch");
      assert_add_ovf_R3: assert (overflow_o == add_ovf_ref) else $error("R3 overflow mismatch");
    end
    if (op_code_i == CODE_SUB) begin
      assert_dif_R4: assert (result_o == dif_ref) else $error("R4 difference mismatch");
    end
    if (op_code_i == CODE_SLT) begin
      assert_less_R5: assert (result_o == lt_ref) else $error("R5 less-than mismatch");
    end
  end

endmodule

bind bitslice_alu alu_check #(.WIDTH(WIDTH)) u_alu_check (
  .a_i        (a_i),
  .b_i        (b_i),
  .op_code_i  (op_code_i),
  .result_o   (result_o),
  .overflow_o (overflow_o)
);

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb;
  import alu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MIN_V = 32'h8000_0000;
  localparam logic [31:0] MAX_V = 32'h7fff_ffff;

  logic        clk = 1'b0;
  logic [31:0] a, b, res;
  logic [3:0]  code;
  logic        zero, ovf;
  logic [3:0]  a4, b4, res4;
  logic [3:0]  code4;
  logic        zero4, ovf4;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitslice_alu #(.WIDTH(32)) u_dut (
    .a_i(a), .b_i(b), .op_code_i(code),
    .result_o(res), .zero_o(zero), .overflow_o(ovf)
  );

  bitslice_alu #(.WIDTH(4)) u_dut_w4 (
    .a_i(a4), .b_i(b4), .op_code_i(code4),
    .result_o(res4), .zero_o(zero4), .overflow_o(ovf4)
  );

  function automatic logic [31:0] ref_res(logic [31:0] x, logic [31:0] y, logic [3:0] c);
    case (c)
      CODE_AND: return x & y;
      CODE_OR:  return x | y;
      CODE_ADD: return x + y;
      CODE_SUB: return x - y;
      CODE_SLT: return {31'd0, $signed(x) < $signed(y)};
      CODE_NOR: return ~(x | y);
      default:  return 32'd0;
    endcase
  endfunction

  function automatic logic ref_ovf(logic [31:0] x, logic [31:0] y, logic [3:0] c);
    logic [31:0] s;
    if (c == CODE_ADD) begin
      s = x + y;
      return (x[31] == y[31]) && (s[31] != x[31]);
    end
    s = x - y;
    return (x[31] != y[31]) && (s[31] != x[31]);
  endfunction

  function automatic string tag_of(logic [3:0] c);
    case (c)
      CODE_AND: return "R1";
      CODE_OR:  return "R2";
      CODE_ADD: return "R3";
      CODE_SUB: return "R4";
      CODE_SLT: return "R5";
      default:  return "R6";
    endcase
  endfunction

  function automatic logic [31:0] pick();
    logic [31:0] r;
    r = $urandom;
    case (r[2:0])
      3'd0: return MIN_V;
      3'd1: return MAX_V;
      3'd2: return 32'hffff_ffff;
      3'd3: return {31'd0, r[3]};
      default: return $urandom;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on falling edge, sample a quarter period later (R8: no edge in between)
  task automatic run(logic [31:0] x, logic [31:0] y, logic [3:0] c);
    logic [31:0] e;
    @(negedge clk);
    a = x; b = y; code = c;
    #(CLK_PERIOD/4);
    e = ref_res(x, y, c);
    chk(tag_of(c), res, e);
    chk("R7", {31'd0, zero}, {31'd0, e == 32'd0});
    if (c == CODE_ADD || c == CODE_SUB || c == CODE_SLT)
      chk(c == CODE_ADD ? "R3" : "R4", {31'd0, ovf}, {31'd0, ref_ovf(x, y, c)});
  endtask

  task automatic run4(logic [3:0] x, logic [3:0] y, logic [3:0] c);
    logic [3:0] d;
    @(negedge clk);
    a4 = x; b4 = y; code4 = c;
    #(CLK_PERIOD/4);
    d = x - y;
    if (c == CODE_SLT)
      chk("R9", {28'd0, res4}, {31'd0, $signed(x) < $signed(y)});
    else
      chk("R9", {31'd0, ovf4}, {31'd0, (x[3] != y[3]) && (d[3] != x[3])});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_ret;
    logic [3:0]  codes [6];
    codes = '{CODE_AND, CODE_OR, CODE_ADD, CODE_SUB, CODE_SLT, CODE_NOR};
    seed_ret = $urandom(32'h5eed_0042);
    a = '0; b = '0; code = CODE_AND;
    a4 = '0; b4 = '0; code4 = CODE_SLT;
    #(CLK_PERIOD/4);
    // idle state: zero inputs, AND -> zero result
    chk("R7", res, 32'd0);
    chk("R7", {31'd0, zero}, 32'd1);
    chk("R8", {31'd0, ovf}, 32'd0);

    // directed corners
    run(MIN_V, 32'd1, CODE_SLT);        // R5 overflowing subtract, true 1
    run(MAX_V, 32'hffff_ffff, CODE_SLT);// R5 overflowing subtract, true 0
    run(MIN_V, MAX_V, CODE_SLT);
    run(MAX_V, MIN_V, CODE_SLT);
    run(32'd5, 32'd5, CODE_SLT);
    run(32'hffff_ffff, 32'd0, CODE_SLT);
    run(MAX_V, 32'd1, CODE_ADD);        // R3 positive overflow
    run(MIN_V, 32'hffff_ffff, CODE_ADD);// R3 negative overflow
    run(MAX_V, 32'hffff_ffff, CODE_SUB);// R4 overflow
    run(32'd7, 32'd7, CODE_SUB);        // R7 zero from subtract
    run(32'd0, 32'd0, CODE_NOR);        // R6 all ones
    run(32'hf0f0_0f0f, 32'h0ff0_00ff, CODE_NOR);

    // constrained random over all codes
    for (int n = 0; n < 2400; n++) begin
      logic [31:0] r;
      r = $urandom;
      run(pick(), pick(), codes[r % 6]);
    end

    // R9: 4-bit instance, wrapping example then exhaustive sweep
    run4(4'b1001, 4'b0110, CODE_SLT);
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        run4(x[3:0], y[3:0], CODE_SLT);
        run4(x[3:0], y[3:0], CODE_SUB);
      end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule